// File: doc/BRIEF.md
# Serial ADC Sampling Frame Controller

This block is the master side of a three-wire link to a serial successive-approximation converter. It drives an active-low chip select, which also serves as the frame signal, and a serial clock. It reads one conversion word from the converter's data line in each frame. The serial clock comes from dividing the system clock. A sample timer counts whole serial-clock periods, so every frame begins on a falling edge of the serial clock, and the spacing between samples is always an exact whole number of serial periods.

Two selectors are set separately. One gives the converter's native word length, and the other gives the frame length the host wants to run. Either one can be 16, 14 or 12 clocks. When the frame is longer than the native word, the bits that arrive after the converter has released its line are dropped. The kept bits are returned right-justified, and a one-cycle strobe marks each result. A sample request that comes too early, while a frame is still running, produces an overrun pulse. That request is dropped and no frame is started early.

The configuration inputs are expected to stay constant while `enable` is high. Dropping `enable` stops all activity and returns both lines to idle.

Top module: `adc_sample_frame`

## Requirements
- R1: While the synchronous active-high reset is asserted, and on the first cycle after it, `csN` and `sclk` are 1, and `resultValid`, `overrun` and `result` are 0.
- R2: While `enable` is 1, `sclk` toggles every `divSel`+1 clock cycles. Its first toggle after `enable` rises is a fall, so one serial period is 2×(`divSel`+1) cycles.
- R3: The sample timer issues a request on every P-th falling edge of `sclk` after `enable` rises, where P = max(`periodSel`, 2). A request accepted while idle pulls `csN` low on the same clock edge that pulls `sclk` low. The first frame therefore comes only after `sclk` has been high, then low, then high.
- R4: Length codes are the same for both selectors: 0 = 16 clocks, 1 = 14, 2 and 3 = 12. `csN` stays low for exactly L serial periods, where L = max(frame length, native length), and it rises with the L-th following fall of `sclk`.
- R5: `sdata` is sampled on the rising edges of `sclk` while `csN` is low, and the first sampled bit is the MSB. The first N bits (N = native length) appear right-justified in `result`, and the bits above them are 0.
- R6: Bits sampled after the first N of a frame have no effect on `result`.
- R7: `resultValid` is a one-cycle pulse in the cycle after `csN` returns high at the end of a complete frame. `result` holds its value until the next pulse.
- R8: A request that occurs while a frame is running, including on the falling edge that ends it, raises `overrun` for one cycle and does not start a frame.
- R9: While `enable` is 0, `csN` and `sclk` are 1 from the next cycle. A frame in progress is abandoned and gives no `resultValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the serial clock and sample timer |
| divSel | input | 8 | Serial clock half-period, minus one, in system cycles |
| natCode | input | 2 | Converter native word length code |
| frmCode | input | 2 | Requested frame length code |
| periodSel | input | 16 | Sample period in serial-clock periods |
| sdata | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low chip select / frame |
| sclk | output | 1 | Serial clock, idles high |
| result | output | 16 | Right-justified conversion word |
| resultValid | output | 1 | One-cycle strobe for a new result |
| overrun | output | 1 | One-cycle pulse for a rejected early request |

## Verification
The tests run several settings of divisor, native length, frame length and period, and every cycle is compared against a behavioural model.

- **Equal native and frame lengths, loose period.** Checks plain capture and the whole-period spacing.
- **Frame longer than the native word.** The converter model drives ones after its last bit, so any leak of trailing bits into `result` would show.
- **Period of exactly the frame length plus one.** Confirms that the minimum gap is accepted.
- **Period one shorter than that.** Produces alternating frames and overruns, which separates a correct busy test from an off-by-one in it.
- **Period below two, and disabling mid-frame.** These exercise the period clamp and the abort path.

// File: rtl/adc_frame_pkg.sv
package adc_frame_pkg;
  localparam int WORD_W = 16;
  localparam int LEN_W  = 5;

  typedef struct packed {
    logic clear;    // frame start: empty the shift register
    logic shift;    // take one data bit
    logic capture;  // move the word to the output
  } dp_strobe_t;

  function automatic logic [LEN_W-1:0] lenOf(input logic [1:0] code);
    case (code)
      2'd0:    lenOf = LEN_W'(16);
      2'd1:    lenOf = LEN_W'(14);
      default: lenOf = LEN_W'(12);
    endcase
  endfunction
endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [DIV_W-1:0] divSel,
  output logic             sclk,
  output logic             fallTick,
  output logic             riseTick
);
  logic [DIV_W-1:0] divCnt;
  logic             tick;

  assign tick     = enable && (divCnt == divSel);
  assign fallTick = tick && sclk;
  assign riseTick = tick && !sclk;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      divCnt <= '0;
      sclk   <= 1'b1;
    end else if (divCnt == divSel) begin
      divCnt <= '0;
      sclk   <= ~sclk;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                fallTick,
  input  logic                riseTick,
  input  logic [1:0]          natCode,
  input  logic [1:0]          frmCode,
  input  logic [PERIOD_W-1:0] periodSel,
  output logic                csN,
  output logic                overrun,
  output logic [LEN_W-1:0]    natLen,
  output dp_strobe_t          strb
);
  typedef enum logic {ST_IDLE, ST_ACTIVE} state_t;

  state_t              state;
  logic [PERIOD_W-1:0] timerCnt;
  logic [PERIOD_W-1:0] periodEff;
  logic [LEN_W-1:0]    fallCnt, bitCnt, lenQ;
  logic [LEN_W-1:0]    natNow, frmNow, lenNow;
  logic                request, doneQ;

  assign natNow    = lenOf(natCode);
  assign frmNow    = lenOf(frmCode);
  assign lenNow    = (natNow > frmNow) ? natNow : frmNow;
  assign periodEff = (periodSel < PERIOD_W'(2)) ? PERIOD_W'(2) : periodSel;
  assign request   = fallTick && (timerCnt == periodEff - PERIOD_W'(1));

  assign strb.clear   = (state == ST_IDLE) && request;
  assign strb.shift   = (state == ST_ACTIVE) && riseTick && (bitCnt < natLen);
  assign strb.capture = doneQ && enable;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      state    <= ST_IDLE;
      csN      <= 1'b1;
      overrun  <= 1'b0;
      doneQ    <= 1'b0;
      timerCnt <= '0;
      fallCnt  <= '0;
      bitCnt   <= '0;
      lenQ     <= LEN_W'(WORD_W);
      natLen   <= LEN_W'(WORD_W);
    end else begin
      doneQ   <= 1'b0;
      overrun <= 1'b0;
      if (fallTick) timerCnt <= request ? '0 : timerCnt + 1'b1;
      case (state)
        ST_IDLE: begin
          if (request) begin
            state   <= ST_ACTIVE;
            csN     <= 1'b0;
            fallCnt <= '0;
            bitCnt  <= '0;
            natLen  <= natNow;
            lenQ    <= lenNow;
          end
        end
        default: begin
          if (riseTick) bitCnt <= bitCnt + 1'b1;
          if (fallTick) begin
            if (request) overrun <= 1'b1;
            if (fallCnt == lenQ - LEN_W'(1)) begin
              state <= ST_IDLE;
              csN   <= 1'b1;
              doneQ <= 1'b1;
            end else begin
              fallCnt <= fallCnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  AST_OVERRUN_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    overrun |-> !$past(csN)); // R8

  AST_FRAME_RISE_COUNT: assert property (@(posedge clk) disable iff (rst)
    doneQ |-> ($past(bitCnt) == lenQ)); // R4
endmodule

// File: rtl/adc_frame_dp.sv
module adc_frame_dp
  import adc_frame_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sdata,
  input  dp_strobe_t        strb,
  input  logic [LEN_W-1:0]  natLen,
  output logic [WORD_W-1:0] result,
  output logic              resultValid
);
  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (strb.clear) begin
      shiftReg <= '0;
    end else if (strb.shift) begin
      shiftReg <= {shiftReg[WORD_W-2:0], sdata};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result      <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= strb.capture;
      if (strb.capture) result <= shiftReg;
    end
  end

  AST_RESULT_FITS: assert property (@(posedge clk) disable iff (rst)
    resultValid |-> ((result >> natLen) == '0)); // R6
endmodule

// File: rtl/adc_sample_frame.sv
module adc_sample_frame
  import adc_frame_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [DIV_W-1:0]    divSel,
  input  logic [1:0]          natCode,
  input  logic [1:0]          frmCode,
  input  logic [PERIOD_W-1:0] periodSel,
  input  logic                sdata,
  output logic                csN,
  output logic                sclk,
  output logic [WORD_W-1:0]   result,
  output logic                resultValid,
  output logic                overrun
);
  logic             fallTick, riseTick;
  logic [LEN_W-1:0] natLen;
  dp_strobe_t       strb;

  adc_sclk_gen #(.DIV_W(DIV_W)) i_sclk (
    .clk(clk), .rst(rst), .enable(enable), .divSel(divSel),
    .sclk(sclk), .fallTick(fallTick), .riseTick(riseTick)
  );

  adc_frame_ctrl #(.PERIOD_W(PERIOD_W)) i_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .fallTick(fallTick),
    .riseTick(riseTick), .natCode(natCode), .frmCode(frmCode),
    .periodSel(periodSel), .csN(csN), .overrun(overrun),
    .natLen(natLen), .strb(strb)
  );

  adc_frame_dp i_dp (
    .clk(clk), .rst(rst), .sdata(sdata), .strb(strb), .natLen(natLen),
    .result(result), .resultValid(resultValid)
  );

  AST_CS_ON_SCLK_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(csN) |-> $fell(sclk)); // R3

  AST_VALID_AFTER_FRAME: assert property (@(posedge clk) disable iff (rst)
    ($rose(csN) && $past(enable)) |=> resultValid); // R7

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (csN && sclk)); // R9
endmodule

// File: tb/test_adc_sample_frame.sv
module test_adc_sample_frame;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [7:0]  divSel = 8'd1;
  logic [1:0]  natCode = 2'd0, frmCode = 2'd0;
  logic [15:0] periodSel = 16'd20;
  logic        sdata = 1'b0;
  logic        csN, sclk, resultValid, overrun;
  logic [15:0] result;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  adc_sample_frame i_adc_sample_frame (
    .clk(clk), .rst(rst), .enable(en), .divSel(divSel), .natCode(natCode),
    .frmCode(frmCode), .periodSel(periodSel), .sdata(sdata), .csN(csN),
    .sclk(sclk), .result(result), .resultValid(resultValid), .overrun(overrun)
  );

  function automatic int lenB(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 14 : 12;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: counts cycles, falls and frames as integers
  int  n, fallCnt, startF, nat, lenF, perEff;
  bit  eSclk = 1, eCs = 1, eValid = 0, eOv = 0, pend = 0, active = 0, prevECs = 1;
  int  wq[$];

  always @(posedge clk) begin
    nat    = lenB(natCode);
    lenF   = (nat > lenB(frmCode)) ? nat : lenB(frmCode);
    perEff = (periodSel < 2) ? 2 : int'(periodSel);
    prevECs = eCs;
    if (rst || !en) begin
      n = 0; eSclk = 1; eCs = 1; eValid = 0; eOv = 0; pend = 0;
      fallCnt = 0; active = 0; startF = 0; wq.delete();
    end else begin
      bit endedNow;
      endedNow = 0;
      n++;
      eValid = pend; pend = 0; eOv = 0;
      if (n % (int'(divSel) + 1) == 0) begin
        if (eSclk) begin
          eSclk = 0;
          fallCnt++;
          if (active && fallCnt == startF + lenF) begin
            eCs = 1; active = 0; pend = 1; endedNow = 1;
          end
          if (fallCnt % perEff == 0) begin
            if (!active && !endedNow) begin
              eCs = 0; active = 1; startF = fallCnt;
            end else eOv = 1;
          end
        end else eSclk = 1;
      end
    end
  end

  // converter model: next bit after each sclk fall, ones after its word
  int  k, wordIdx = 0, curW, lcg = 32'h1234;
  bit  prevCs = 1, prevSclk = 1;
  function automatic bit bitOf(input int w, input int idx, input int nb);
    return (idx < nb) ? w[nb-1-idx] : 1'b1;
  endfunction

  initial forever begin
    @(negedge clk);
    if (prevCs && !csN) begin
      int nb;
      nb = lenB(natCode);
      case (wordIdx % 5)
        0: curW = 32'hFFFF;
        1: curW = 32'hA5C3;
        2: curW = 32'h0001;
        3: curW = 1 << (nb - 1);
        default: begin lcg = lcg * 1103515245 + 12345; curW = (lcg >>> 8); end
      endcase
      curW = curW & ((1 << nb) - 1);
      wordIdx++;
      wq.push_back(curW);
      k = 0;
      sdata = bitOf(curW, k, nb);
    end else if (!csN && prevSclk && !sclk) begin
      k++;
      sdata = bitOf(curW, k, lenB(natCode));
    end
    prevCs = csN; prevSclk = sclk;
  end

  // per-cycle comparison
  initial forever begin
    string t;
    @(negedge clk);
    if (finished) break;
    if (rst) t = "R1"; else if (!en) t = "R9"; else t = "";
    chk(t == "" ? "R2" : t, "sclk", sclk, eSclk);
    chk(t == "" ? ((prevECs && !eCs) ? "R3" : "R4") : t, "csN", csN, eCs);
    chk(t == "" ? "R7" : t, "resultValid", resultValid, eValid);
    chk(t == "" ? "R8" : t, "overrun", overrun, eOv);
    if (eValid) begin
      if (wq.size() == 0) chk("R7", "pending word", 0, 1);
      else begin
        chk((lenB(natCode) < lenB(frmCode)) ? "R6" : "R5", "result",
            result, wq.pop_front());
      end
    end
  end

  task automatic runPhase(input int d, input logic [1:0] nc, input logic [1:0] fc,
                          input int p, input int cycles);
    @(negedge clk);
    en = 1'b0;
    divSel = 8'(d); natCode = nc; frmCode = fc; periodSel = 16'(p);
    repeat (3) @(negedge clk);
    en = 1'b1;
    repeat (cycles) @(negedge clk);
    en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset csN", csN, 1);
    chk("R1", "reset sclk", sclk, 1);
    chk("R1", "reset result", result, 0);
    chk("R1", "reset valid", resultValid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "post-reset overrun", overrun, 0);
    runPhase(1, 2'd0, 2'd0, 20, 500);   // R5 plain capture
    runPhase(0, 2'd2, 2'd0, 17, 320);   // R6 trailing bits, minimum gap
    runPhase(2, 2'd1, 2'd2, 14, 800);   // R4 clamp, R8 overruns
    runPhase(3, 2'd1, 2'd0, 30, 1000);  // R6 14 bits in a 16 frame
    runPhase(0, 2'd2, 2'd2, 1, 200);    // R3 period clamp
    // R9 abort mid-frame
    @(negedge clk);
    divSel = 8'd1; natCode = 2'd0; frmCode = 2'd0; periodSel = 16'd3;
    en = 1'b1;
    repeat (30) @(negedge clk);
    chk("R9", "frame running before abort", csN, 0);
    en = 1'b0;
    repeat (20) @(negedge clk);
    chk("R9", "abort csN", csN, 1);
    runPhase(1, 2'd0, 2'd0, 17, 400);   // recovery after abort
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule